// File: doc/BRIEF.md
# Bit-Serial-Skewed Pipelined Accumulator

This block keeps a running 32-bit sum of a stream of words, with one full-adder cell for each bit position. A word can arrive on every clock cycle. Its bits do not enter the cells at the same moment. Bit position k of the word that is sampled on cycle i is handled by cell k on cycle i + 2k. The carry that cell k produces reaches cell k+1 through two register stages, so it meets the next bit of the same word on that cycle. The critical path is therefore one full adder plus one flop, at any word width.

Each incoming word has a gate bit. When the gate is low, the word adds zero, but it still produces a result. A clear input resets the sum to zero. The clear moves along the same diagonal as the data, so the words that are already in the array are not disturbed by it. On the output side a de-skew delay holds the low bits back, so that all 32 bits of each updated sum appear together with a valid flag, a fixed number of cycles after the word was sampled. Words are summed in the order they arrive. The result wraps modulo 2^32.

Top module: `bitmac_array`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0 and `acc_out` is 0. The sum restarts from zero, so the first word after reset gives its own value, even if words were in flight when reset was asserted.
- R2: Each cycle with `in_valid`=1, `in_gate`=1 and `in_clear`=0 adds `in_word` to the running sum. The result includes carries that travel across the whole width.
- R3: A word with `in_gate`=0 adds zero, but it still produces one output carrying the unchanged sum.
- R4: The sum is taken modulo 2^32. The carry out of bit 31 is discarded.
- R5: The result for a word sampled at rising edge S is presented with `out_valid`=1 right after rising edge S+62, that is, 2·(32−1) edges later. All 32 bits are valid in that same cycle.
- R6: Words may be sampled on consecutive cycles. Each valid word produces exactly one result, and the results come out in arrival order.
- R7: `in_clear`=1 together with `in_valid`=1 zeroes the sum before that word is added. The output is then the gated word alone.
- R8: `in_clear`=1 with `in_valid`=0 zeroes the sum and produces no output. The next word's result equals that word alone.
- R9: Cycles with `in_valid`=0 and `in_clear`=0 produce no output and leave the sum unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A word is presented this cycle |
| in_gate | input | 1 | 1: add the word; 0: add zero |
| in_clear | input | 1 | Zero the sum before this cycle's word |
| in_word | input | 32 | Word to accumulate |
| acc_out | output | 32 | Running sum, de-skewed |
| out_valid | output | 1 | `acc_out` holds the result for one word |

## Verification
The words are chosen so that a carry generated in bit 3 has to travel into bit 31. This exposes a carry pipeline with the wrong number of stages or a skew step that does not match, since both bring the top bits out one cycle off. Sums that pass 2^32, and an all-ones word followed by +1, separate a discarded carry from a carry that is kept or that wraps into bit 0. Gated-off words, cleared words, clears without a word, idle gaps and a reset in the middle of a run separate the hold, clear and restart paths. Every result is also checked for the exact cycle it appears, which catches any skew or de-skew length that is off by one.

// File: rtl/bitmac_pkg.sv
package bitmac_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned STEP   = 2;

    // Control and carry that travel diagonally from cell to cell.
    typedef struct packed {
        logic valid;
        logic gate;
        logic clear;
        logic carry;
    } diag_t;

    typedef struct packed {
        logic sum;
        logic carry;
    } fa_t;

    function automatic logic fa_sum(input logic a, input logic b, input logic c);
        return a ^ b ^ c;
    endfunction

    function automatic logic fa_carry(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic fa_t full_add(input logic a, input logic b, input logic c);
        fa_t r;
        r.sum   = fa_sum(a, b, c);
        r.carry = fa_carry(a, b, c);
        return r;
    endfunction

endpackage

// File: rtl/skew_line.sv
module skew_line #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (DEPTH == 0) begin : g_pass
            assign q = d;
        end else begin : g_regs
            logic [DEPTH-1:0] sr;
            always_ff @(posedge clk) begin
                if (rst) begin
                    sr <= '0;
                end else begin
                    sr[0] <= d;
                    for (int i = 1; i < int'(DEPTH); i++) begin
                        sr[i] <= sr[i-1];
                    end
                end
            end
            assign q = sr[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/mac_bit_cell.sv
module mac_bit_cell
    import bitmac_pkg::*;
#(
    parameter int unsigned STEP_N = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  diag_t diag_i,
    input  logic  data_i,
    output logic  acc_o,
    output diag_t diag_o
);
    logic  acc_q;
    logic  a_eff;
    logic  b_eff;
    fa_t   fa;
    diag_t nxt;
    diag_t pipe [STEP_N];

    assign a_eff = diag_i.clear ? 1'b0 : acc_q;
    assign b_eff = data_i & diag_i.gate & diag_i.valid;
    assign fa    = full_add(a_eff, b_eff, diag_i.carry);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= 1'b0;
        end else if (diag_i.valid || diag_i.clear) begin
            acc_q <= fa.sum;
        end
    end

    always_comb begin
        nxt       = diag_i;
        nxt.carry = diag_i.valid & fa.carry;
    end

    // The carry and the control bits wait STEP_N cycles before entering the next cell.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(STEP_N); i++) begin
                pipe[i] <= '0;
            end
        end else begin
            pipe[0] <= nxt;
            for (int i = 1; i < int'(STEP_N); i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign diag_o = pipe[STEP_N-1];
    assign acc_o  = acc_q;

    // R8: a clear with no word leaves this bit at zero
    a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        (diag_i.clear && !diag_i.valid) |=> (acc_q == 1'b0));

    // R9: an idle slot leaves this bit unchanged
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!diag_i.valid && !diag_i.clear) |=> $stable(acc_q));

    // R2: a carry only travels together with a word
    a_r2_carry_with_word: assert property (@(posedge clk) disable iff (rst)
        diag_o.carry |-> diag_o.valid);
endmodule

// File: rtl/mac_msb_cell.sv
module mac_msb_cell
    import bitmac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  diag_t diag_i,
    input  logic  data_i,
    output logic  acc_o,
    output logic  done_o
);
    logic acc_q;
    logic done_q;
    logic a_eff;
    logic b_eff;

    assign a_eff = diag_i.clear ? 1'b0 : acc_q;
    assign b_eff = data_i & diag_i.gate & diag_i.valid;

    // The top cell keeps only the sum; its carry is dropped (R4).
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= diag_i.valid;
            if (diag_i.valid || diag_i.clear) begin
                acc_q <= fa_sum(a_eff, b_eff, diag_i.carry);
            end
        end
    end

    assign acc_o  = acc_q;
    assign done_o = done_q;

    a_r8_msb_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        (diag_i.clear && !diag_i.valid) |=> (acc_q == 1'b0));

    a_r9_msb_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!diag_i.valid && !diag_i.clear) |=> $stable(acc_q));
endmodule

// File: rtl/bitmac_array.sv
module bitmac_array
    import bitmac_pkg::*;
#(
    parameter int unsigned W      = WORD_W,
    parameter int unsigned STEP_N = STEP
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         in_gate,
    input  logic         in_clear,
    input  logic [W-1:0] in_word,
    output logic [W-1:0] acc_out,
    output logic         out_valid
);
    localparam int unsigned LATENCY = (W - 1) * STEP_N;
    localparam int unsigned CNT_W   = $clog2(LATENCY + 2) + 1;

    diag_t        diag [W];
    logic [W-1:0] bit_sk;
    logic [W-1:0] acc_bit;

    assign diag[0] = '{valid: in_valid, gate: in_gate, clear: in_clear, carry: 1'b0};

    generate
        for (genvar k = 0; k < int'(W); k++) begin : g_bit
            skew_line #(.DEPTH(k * STEP_N)) u_lead (
                .clk (clk),
                .rst (rst),
                .d   (in_word[k]),
                .q   (bit_sk[k])
            );

            if (k < int'(W) - 1) begin : g_cell
                mac_bit_cell #(.STEP_N(STEP_N)) u_cell (
                    .clk    (clk),
                    .rst    (rst),
                    .diag_i (diag[k]),
                    .data_i (bit_sk[k]),
                    .acc_o  (acc_bit[k]),
                    .diag_o (diag[k+1])
                );
            end else begin : g_msb
                mac_msb_cell u_msb (
                    .clk    (clk),
                    .rst    (rst),
                    .diag_i (diag[k]),
                    .data_i (bit_sk[k]),
                    .acc_o  (acc_bit[k]),
                    .done_o (out_valid)
                );
            end

            skew_line #(.DEPTH((W - 1 - k) * STEP_N)) u_trail (
                .clk (clk),
                .rst (rst),
                .d   (acc_bit[k]),
                .q   (acc_out[k])
            );
        end
    endgenerate

    // Number of words sampled whose result has not yet been presented.
    logic [CNT_W-1:0] inflight;
    always_ff @(posedge clk) begin
        if (rst) begin
            inflight <= '0;
        end else begin
            inflight <= inflight + CNT_W'(in_valid) - CNT_W'(out_valid);
        end
    end

    // R5: a result is never presented before its word was sampled
    a_r5_no_orphan: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (inflight != '0));

    // R6: no word is held longer than the pipeline depth
    a_r6_inflight_bound: assert property (@(posedge clk) disable iff (rst)
        inflight <= CNT_W'(LATENCY + 1));

    // R1: the cycle after reset has no result
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> !out_valid);
endmodule

// File: tb/sim_bitmac_array.sv
module sim_bitmac_array;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 32;
    localparam int LATENCY    = 62;
    localparam int NVEC       = 16;

    typedef struct packed {
        logic        v;
        logic        g;
        logic        c;
        logic [31:0] word;
        logic [31:0] expv;
        logic [7:0]  req;
    } vec_t;

    typedef struct {
        logic [31:0] val;
        int          due;
        int          req;
    } exp_t;

    // Back-to-back stimulus with the expected running sum.
    localparam vec_t TBL [NVEC] = '{
        '{1'b1, 1'b1, 1'b0, 32'h0000_0005, 32'h0000_0005, 8'd1}, // R1 first word after reset
        '{1'b1, 1'b1, 1'b0, 32'h0000_0003, 32'h0000_0008, 8'd2}, // R2
        '{1'b1, 1'b1, 1'b0, 32'h7FFF_FFF8, 32'h8000_0000, 8'd2}, // R2 full-width carry
        '{1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h8000_0000, 8'd3}, // R3 gated off
        '{1'b1, 1'b1, 1'b0, 32'h8000_0000, 32'h0000_0000, 8'd4}, // R4 wrap
        '{1'b0, 1'b1, 1'b0, 32'h1234_5678, 32'h0000_0000, 8'd9}, // R9 idle
        '{1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'd4}, // R4
        '{1'b1, 1'b1, 1'b0, 32'h0000_0001, 32'h0000_0000, 8'd4}, // R4 all-ones plus one
        '{1'b0, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000, 8'd9}, // R9 idle
        '{1'b1, 1'b1, 1'b1, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 8'd7}, // R7 clear with word
        '{1'b1, 1'b1, 1'b0, 32'h5A5A_5A5A, 32'hFFFF_FFFF, 8'd2}, // R2
        '{1'b0, 1'b0, 1'b1, 32'hDEAD_BEEF, 32'h0000_0000, 8'd8}, // R8 clear alone
        '{1'b1, 1'b1, 1'b0, 32'h0000_00FF, 32'h0000_00FF, 8'd8}, // R8 sum restarted
        '{1'b1, 1'b0, 1'b1, 32'h1111_1111, 32'h0000_0000, 8'd7}, // R7 clear, gated off
        '{1'b1, 1'b1, 1'b0, 32'h1357_9BDF, 32'h1357_9BDF, 8'd6}, // R6
        '{1'b1, 1'b1, 1'b0, 32'h2468_ACE0, 32'h37C0_48BF, 8'd6}  // R6
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_gate = 1'b0;
    logic          in_clear = 1'b0;
    logic [W-1:0]  in_word = '0;
    logic [W-1:0]  acc_out;
    logic          out_valid;

    int   cyc = 0;
    int   n_checks = 0;
    int   n_fails = 0;
    bit   monitor_on = 1'b0;
    bit   finished = 1'b0;
    exp_t exp_q [$];

    bitmac_array u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_gate   (in_gate),
        .in_clear  (in_clear),
        .in_word   (in_word),
        .acc_out   (acc_out),
        .out_valid (out_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic send(input logic v, input logic g, input logic c,
                        input logic [31:0] w, input logic [31:0] expv, input int req);
        exp_t e;
        @(negedge clk);
        in_valid = v;
        in_gate  = g;
        in_clear = c;
        in_word  = w;
        if (v) begin
            e.val = expv;
            e.due = cyc + 1 + LATENCY;
            e.req = req;
            exp_q.push_back(e);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            send(1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 9);
        end
    endtask

    // Each result is compared with its value and its cycle (R5, R6); a result nobody expects fails R9.
    always @(negedge clk) begin
        if (monitor_on && !rst) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, 9, "unexpected result", acc_out, 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(acc_out == e.val, e.req, "sum", acc_out, e.val);
                    chk(cyc == e.due, 5, "result cycle", 32'(cyc), 32'(e.due));
                end
            end else if (exp_q.size() != 0 && cyc > exp_q[0].due) begin
                chk(1'b0, 5, "missing result", 32'(cyc), 32'(exp_q[0].due));
                void'(exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(out_valid == 1'b0, 1, "out_valid after reset", 32'(out_valid), 32'h0);
        chk(acc_out == '0, 1, "acc_out after reset", acc_out, 32'h0);
        monitor_on = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            send(TBL[i].v, TBL[i].g, TBL[i].c, TBL[i].word, TBL[i].expv, int'(TBL[i].req));
        end

        // R9 long gap, then the sum continues unchanged
        idle(100);
        send(1'b1, 1'b1, 1'b0, 32'h0000_0001, 32'h37C0_48C0, 9);
        idle(LATENCY + 5);
        chk(exp_q.size() == 0, 6, "results outstanding", 32'(exp_q.size()), 32'h0);

        // R1 reset in mid-run discards words in flight
        send(1'b1, 1'b1, 1'b0, 32'h0000_0010, 32'h0, 1);
        send(1'b1, 1'b1, 1'b0, 32'h0000_0020, 32'h0, 1);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        exp_q.delete();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk(out_valid == 1'b0, 1, "out_valid after mid-run reset", 32'(out_valid), 32'h0);
        idle(LATENCY + 5);
        send(1'b1, 1'b1, 1'b0, 32'h0000_0042, 32'h0000_0042, 1);
        idle(LATENCY + 5);

        // R6 every word produced exactly one result
        chk(exp_q.size() == 0, 6, "results outstanding at end", 32'(exp_q.size()), 32'h0);
        finish_run();
    end
endmodule